// File: doc/BRIEF.md
# Machine Cycle Sequencer

The sequencer splits the incoming clock into machine cycles of eight clock periods and walks a small 8-bit processor through its cycle types. An instruction normally takes a fetch cycle followed by one execute cycle, which is sixteen clocks. Between instructions the block can insert a direct-memory-access cycle or an interrupt cycle when a request is pending. Within each cycle it drives two timing pulses. The first marks the moment the upper byte of the multiplexed address is on the bus. The second falls near the end of the cycle and clocks data and I/O flags. The block also drives active-low memory read and write strobes, a 2-bit code that names the current cycle type, and the 3-bit I/O select lines while an I/O instruction executes.

The datapath supplies the fetched opcode, the memory access type of the execute cycle and the direction of a DMA transfer. The block looks only at what it needs to count cycles and to drive the I/O select lines. A pause input freezes the timing generator on a falling clock edge while the clock keeps running. Timing resumes from the same phase once pause is released.

Top module: `cycle_sequencer`

## Requirements
- R1: `phase_o` counts 0 to 7, one step per clock, and wraps to 0, so a machine cycle lasts eight clocks. Reset gives phase 0 in a fetch cycle.
- R2: `tpa_o` is high only in phase 1 and `tpb_o` only in phase 6, in every cycle type.
- R3: `addr_hi_o` (upper address byte selected) is high in phases 0 and 1 and low in phases 2 to 7.
- R4: With no request pending, a fetch cycle is followed by a single execute cycle and then the next fetch. `state_code_o` reads 00 for fetch, 01 for execute, 10 for DMA and 11 for interrupt.
- R5: An opcode whose upper nibble is hex C, captured in phase 6 of the fetch cycle, gets two consecutive execute cycles.
- R6: A DMA request seen in phase 7 of an execute (final one), DMA or interrupt cycle makes the next cycle a DMA cycle, even when an interrupt is also pending.
- R7: An interrupt request seen in phase 7 of a final execute or DMA cycle, with no DMA request and the enable flag set, makes the next cycle an interrupt cycle and clears the flag. While the flag is clear the request is ignored and a fetch follows. `ie_set_i` sets the flag again, and reset sets it. An interrupt cycle is always followed by a fetch unless DMA is requested.
- R8: `mrd_n_o` is low in phases 2 to 7 of fetch cycles, of execute cycles with `exec_mem_i` = 01, and of DMA cycles with `dma_dir_i` = 0. It is high at all other times.
- R9: `mwr_n_o` is low in phases 5 and 6 of execute cycles with `exec_mem_i` = 10, and of DMA cycles with `dma_dir_i` = 1. Interrupt cycles, and execute cycles with `exec_mem_i` = 00, keep both strobes high.
- R10: During an execute cycle whose opcode has upper nibble 6 and lower nibble other than 0 or 8, `nline_o` carries opcode bits 2:0. Otherwise it is 0.
- R11: `pause_i` is sampled on the falling clock edge. From the next rising edge on, the phase, the cycle type and every output hold. After release, counting resumes at the following phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pause_i | input | 1 | Freeze request, taken on the falling clock edge |
| opcode_i | input | 8 | Instruction byte, captured in phase 6 of a fetch cycle |
| exec_mem_i | input | 2 | Execute-cycle access: 00 none, 01 read, 10 write, 11 none |
| dma_req_i | input | 1 | DMA request |
| dma_dir_i | input | 1 | DMA direction: 1 writes memory, 0 reads memory |
| int_req_i | input | 1 | Interrupt request |
| ie_set_i | input | 1 | Sets the interrupt enable flag |
| phase_o | output | 3 | Clock phase within the machine cycle |
| state_code_o | output | 2 | Current cycle type |
| tpa_o | output | 1 | Upper-address strobe pulse |
| tpb_o | output | 1 | End-of-cycle strobe pulse |
| addr_hi_o | output | 1 | High while the upper address byte is selected |
| mrd_n_o | output | 1 | Memory read strobe, active low |
| mwr_n_o | output | 1 | Memory write strobe, active low |
| nline_o | output | 3 | I/O select lines |

## Verification
The embedded properties assume that `pause_i` changes away from the falling clock edge. They also assume that `ie_set_i` is never raised in the same clock that an interrupt is taken. In addition, `exec_mem_i`, `dma_dir_i` and `opcode_i` are taken to be steady for a whole cycle. The directed bench follows these rules. It changes every input just after a rising edge, sets `ie_set_i` only during fetch cycles, and sets each cycle's access type before that cycle's first phase is checked.

// File: rtl/cseq_pkg.sv
`timescale 1ns/1ps
package cseq_pkg;
    typedef enum logic [1:0] {
        ST_FETCH = 2'b00,
        ST_EXEC  = 2'b01,
        ST_DMA   = 2'b10,
        ST_INTR  = 2'b11
    } mstate_e;

    localparam logic [1:0] XM_READ  = 2'b01;
    localparam logic [1:0] XM_WRITE = 2'b10;
endpackage

// File: rtl/cseq_phase.sv
`timescale 1ns/1ps
module cseq_phase #(
    parameter int PHASES = 8,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_i,
    output logic [PW-1:0] phase_o,
    output logic          adv_o,
    output logic          last_o
);
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    logic          frz_d, frz_q;
    logic [PW-1:0] ph_d, ph_q;

    always_comb begin
        frz_d = hold_i;
        ph_d  = ph_q;
        if (!frz_q) begin
            ph_d = (ph_q == LAST) ? '0 : ph_q + PW'(1);
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) frz_q <= 1'b0;
        else        frz_q <= frz_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign phase_o = ph_q;
    assign adv_o   = !frz_q;
    assign last_o  = (ph_q == LAST);

    assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz_q && ph_q != LAST) |=> ph_q == PW'($past(ph_q) + PW'(1)));
    assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz_q && ph_q == LAST) |=> ph_q == '0);
    assert_pause_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frz_q |=> $stable(ph_q));
endmodule

// File: rtl/cseq_ctrl.sv
`timescale 1ns/1ps
module cseq_ctrl
    import cseq_pkg::*;
#(
    parameter int PHASES = 8,
    parameter int OP_W   = 8,
    parameter int TPB_PH = 6,
    localparam int PW = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PW-1:0]   phase_i,
    input  logic            adv_i,
    input  logic            last_i,
    input  logic [OP_W-1:0] opcode_i,
    input  logic            dma_req_i,
    input  logic            int_req_i,
    input  logic            ie_set_i,
    output mstate_e         state_o,
    output logic [OP_W-1:0] op_o
);
    typedef struct packed {
        mstate_e         st;
        logic [OP_W-1:0] op;
        logic            second;
        logic            ie;
    } ctrl_s;

    ctrl_s c_d, c_q;
    logic  long_op;
    logic  boundary;

    assign long_op  = (c_q.op[OP_W-1 -: 4] == 4'hC);
    assign boundary = adv_i && last_i;

    always_comb begin
        c_d = c_q;
        if (adv_i && phase_i == PW'(TPB_PH) && c_q.st == ST_FETCH) c_d.op = opcode_i;
        if (ie_set_i) c_d.ie = 1'b1;
        if (boundary) begin
            unique case (c_q.st)
                ST_FETCH: begin
                    c_d.st     = ST_EXEC;
                    c_d.second = 1'b0;
                end
                ST_EXEC, ST_DMA: begin
                    if (c_q.st == ST_EXEC && long_op && !c_q.second) begin
                        c_d.second = 1'b1;
                    end else begin
                        c_d.second = 1'b0;
                        if (dma_req_i) begin
                            c_d.st = ST_DMA;
                        end else if (int_req_i && c_q.ie) begin
                            c_d.st = ST_INTR;
                            c_d.ie = 1'b0;
                        end else begin
                            c_d.st = ST_FETCH;
                        end
                    end
                end
                ST_INTR: c_d.st = dma_req_i ? ST_DMA : ST_FETCH;
                default: c_d.st = ST_FETCH;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st     <= ST_FETCH;
            c_q.op     <= '0;
            c_q.second <= 1'b0;
            c_q.ie     <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign state_o = c_q.st;
    assign op_o    = c_q.op;

    assert_type_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(c_q.st));
    assert_fetch_then_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && c_q.st == ST_FETCH) |=> c_q.st == ST_EXEC);
    assert_long_twice_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && c_q.st == ST_EXEC && long_op && !c_q.second) |=> c_q.st == ST_EXEC);
    assert_dma_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && dma_req_i && c_q.st != ST_FETCH &&
         !(c_q.st == ST_EXEC && long_op && !c_q.second)) |=> c_q.st == ST_DMA);
    assert_intr_clears_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.st == ST_INTR) |-> !c_q.ie);
endmodule

// File: rtl/cseq_strobe.sv
`timescale 1ns/1ps
module cseq_strobe
    import cseq_pkg::*;
#(
    parameter int PHASES   = 8,
    parameter int OP_W     = 8,
    parameter int TPA_PH   = 1,
    parameter int TPB_PH   = 6,
    parameter int RD_FIRST = 2,
    parameter int WR_FIRST = 5,
    parameter int WR_LAST  = 6,
    localparam int PW = $clog2(PHASES),
    localparam int NW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PW-1:0]   phase_i,
    input  mstate_e         state_i,
    input  logic [OP_W-1:0] op_i,
    input  logic [1:0]      exec_mem_i,
    input  logic            dma_dir_i,
    output logic            tpa_o,
    output logic            tpb_o,
    output logic            addr_hi_o,
    output logic            mrd_n_o,
    output logic            mwr_n_o,
    output logic [NW-1:0]   nline_o
);
    logic [PHASES-1:0] ph_hot;
    logic rd_win, wr_win, rd_cyc, wr_cyc, io_op;

    for (genvar g = 0; g < PHASES; g++) begin : g_hot
        assign ph_hot[g] = (phase_i == PW'(g));
    end

    assign rd_win = |ph_hot[PHASES-1:RD_FIRST];
    assign wr_win = |ph_hot[WR_LAST:WR_FIRST];
    assign io_op  = (op_i[OP_W-1 -: 4] == 4'h6) && (op_i[3:0] != 4'h0) && (op_i[3:0] != 4'h8);

    always_comb begin
        rd_cyc = 1'b0;
        wr_cyc = 1'b0;
        unique case (state_i)
            ST_FETCH: rd_cyc = 1'b1;
            ST_EXEC: begin
                rd_cyc = (exec_mem_i == XM_READ);
                wr_cyc = (exec_mem_i == XM_WRITE);
            end
            ST_DMA: begin
                rd_cyc = !dma_dir_i;
                wr_cyc = dma_dir_i;
            end
            default: ;
        endcase
    end

    assign tpa_o     = ph_hot[TPA_PH];
    assign tpb_o     = ph_hot[TPB_PH];
    assign addr_hi_o = |ph_hot[TPA_PH:0];
    assign mrd_n_o   = !(rd_cyc && rd_win);
    assign mwr_n_o   = !(wr_cyc && wr_win);
    assign nline_o   = (state_i == ST_EXEC && io_op) ? op_i[NW-1:0] : '0;

    assert_pulses_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tpa_o, tpb_o}));
    assert_strobes_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_n_o || mwr_n_o);
    assert_intr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_INTR) |-> (mrd_n_o && mwr_n_o));
    assert_nline_exec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (nline_o != '0) |-> (state_i == ST_EXEC));
    assert_no_strobe_on_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hi_o |-> mrd_n_o && mwr_n_o);
endmodule

// File: rtl/cycle_sequencer.sv
`timescale 1ns/1ps
module cycle_sequencer
    import cseq_pkg::*;
#(
    parameter int PHASES   = 8,
    parameter int OP_W     = 8,
    parameter int TPA_PH   = 1,
    parameter int TPB_PH   = 6,
    parameter int RD_FIRST = 2,
    parameter int WR_FIRST = 5,
    parameter int WR_LAST  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pause_i,
    input  logic [OP_W-1:0]            opcode_i,
    input  logic [1:0]                 exec_mem_i,
    input  logic                       dma_req_i,
    input  logic                       dma_dir_i,
    input  logic                       int_req_i,
    input  logic                       ie_set_i,
    output logic [$clog2(PHASES)-1:0]  phase_o,
    output logic [1:0]                 state_code_o,
    output logic                       tpa_o,
    output logic                       tpb_o,
    output logic                       addr_hi_o,
    output logic                       mrd_n_o,
    output logic                       mwr_n_o,
    output logic [2:0]                 nline_o
);
    localparam int PW = $clog2(PHASES);

    logic [PW-1:0]   phase;
    logic            adv, last;
    mstate_e         state;
    logic [OP_W-1:0] op;

    cseq_phase #(.PHASES(PHASES)) u_phase (
        .clk(clk), .rst_n(rst_n), .hold_i(pause_i),
        .phase_o(phase), .adv_o(adv), .last_o(last)
    );

    cseq_ctrl #(.PHASES(PHASES), .OP_W(OP_W), .TPB_PH(TPB_PH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .phase_i(phase), .adv_i(adv), .last_i(last),
        .opcode_i(opcode_i), .dma_req_i(dma_req_i), .int_req_i(int_req_i),
        .ie_set_i(ie_set_i), .state_o(state), .op_o(op)
    );

    cseq_strobe #(
        .PHASES(PHASES), .OP_W(OP_W), .TPA_PH(TPA_PH), .TPB_PH(TPB_PH),
        .RD_FIRST(RD_FIRST), .WR_FIRST(WR_FIRST), .WR_LAST(WR_LAST)
    ) u_strobe (
        .clk(clk), .rst_n(rst_n), .phase_i(phase), .state_i(state), .op_i(op),
        .exec_mem_i(exec_mem_i), .dma_dir_i(dma_dir_i),
        .tpa_o(tpa_o), .tpb_o(tpb_o), .addr_hi_o(addr_hi_o),
        .mrd_n_o(mrd_n_o), .mwr_n_o(mwr_n_o), .nline_o(nline_o)
    );

    assign phase_o      = phase;
    assign state_code_o = state;
endmodule

// File: tb/cycle_sequencer_bench.sv
`timescale 1ns/1ps
module cycle_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pause_i = 1'b0;
    logic [7:0] opcode_i = 8'h10;
    logic [1:0] exec_mem_i = 2'b00;
    logic       dma_req_i = 1'b0, dma_dir_i = 1'b0, int_req_i = 1'b0, ie_set_i = 1'b0;
    logic [2:0] phase_o;
    logic [1:0] state_code_o;
    logic       tpa_o, tpb_o, addr_hi_o, mrd_n_o, mwr_n_o;
    logic [2:0] nline_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cycle_sequencer u_cycle_sequencer (
        .clk(clk), .rst_n(rst_n), .pause_i(pause_i), .opcode_i(opcode_i),
        .exec_mem_i(exec_mem_i), .dma_req_i(dma_req_i), .dma_dir_i(dma_dir_i),
        .int_req_i(int_req_i), .ie_set_i(ie_set_i), .phase_o(phase_o),
        .state_code_o(state_code_o), .tpa_o(tpa_o), .tpb_o(tpb_o),
        .addr_hi_o(addr_hi_o), .mrd_n_o(mrd_n_o), .mwr_n_o(mwr_n_o), .nline_o(nline_o)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // one full machine cycle, checking every phase against the requirements
    task automatic run_cycle(input int sc, input bit rd, input bit wr, input int n, input string tag);
        for (int ph = 0; ph < 8; ph++) begin
            #0.2;
            chk({tag, " R1 phase"}, phase_o, ph);
            chk({tag, " R4 state code"}, state_code_o, sc);
            chk({tag, " R2 tpa"}, tpa_o, ph == 1);
            chk({tag, " R2 tpb"}, tpb_o, ph == 6);
            chk({tag, " R3 upper byte"}, addr_hi_o, ph < 2);
            chk({tag, " R8 read strobe"}, mrd_n_o, !(rd && ph >= 2));
            chk({tag, " R9 write strobe"}, mwr_n_o, !(wr && (ph == 5 || ph == 6)));
            chk({tag, " R10 nlines"}, nline_o, (sc == 1) ? n : 0);
            tick();
        end
    endtask

    task automatic t_reset_R1();
        #0.5;
        chk("R1 reset phase", phase_o, 0);
        chk("R1 reset state", state_code_o, 0);
        chk("R2 reset tpa", tpa_o, 0);
        chk("R3 reset upper byte", addr_hi_o, 1);
        chk("R8 reset read", mrd_n_o, 1);
        chk("R9 reset write", mwr_n_o, 1);
        @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic t_plain_R4();
        opcode_i = 8'h10; exec_mem_i = 2'b00;
        run_cycle(0, 1, 0, 0, "plain fetch");
        run_cycle(1, 0, 0, 0, "plain exec none");
        opcode_i = 8'h40; exec_mem_i = 2'b01;
        run_cycle(0, 1, 0, 0, "fetch");
        run_cycle(1, 1, 0, 0, "exec read R8");
    endtask

    task automatic t_io_write_R10();
        opcode_i = 8'h63; exec_mem_i = 2'b00;
        run_cycle(0, 1, 0, 0, "io fetch");
        run_cycle(1, 0, 0, 3, "io exec R10");
        opcode_i = 8'h68;
        run_cycle(0, 1, 0, 0, "nibble8 fetch");
        run_cycle(1, 0, 0, 0, "nibble8 exec R10");
        opcode_i = 8'h55; exec_mem_i = 2'b10;
        run_cycle(0, 1, 0, 0, "store fetch");
        run_cycle(1, 0, 1, 0, "store exec R9");
    endtask

    task automatic t_long_R5();
        opcode_i = 8'hC2; exec_mem_i = 2'b01;
        run_cycle(0, 1, 0, 0, "long fetch");
        run_cycle(1, 1, 0, 0, "long exec1 R5");
        run_cycle(1, 1, 0, 0, "long exec2 R5");
        opcode_i = 8'h10; exec_mem_i = 2'b00;
        run_cycle(0, 1, 0, 0, "after long R5");
        run_cycle(1, 0, 0, 0, "after long exec");
    endtask

    task automatic t_dma_R6();
        opcode_i = 8'h10; exec_mem_i = 2'b00;
        dma_req_i = 1'b1; dma_dir_i = 1'b1;
        run_cycle(0, 1, 0, 0, "dma fetch");
        run_cycle(1, 0, 0, 0, "dma exec");
        run_cycle(2, 0, 1, 0, "dma in R6");
        dma_req_i = 1'b0; dma_dir_i = 1'b0;
        run_cycle(2, 1, 0, 0, "dma out R6");
        run_cycle(0, 1, 0, 0, "after dma R6");
        run_cycle(1, 0, 0, 0, "after dma exec");
    endtask

    task automatic t_intr_R7();
        int_req_i = 1'b1;
        run_cycle(0, 1, 0, 0, "int fetch");
        run_cycle(1, 0, 0, 0, "int exec");
        run_cycle(3, 0, 0, 0, "int taken R7");
        run_cycle(0, 1, 0, 0, "post int R7");
        run_cycle(1, 0, 0, 0, "masked exec R7");
        ie_set_i = 1'b1;
        run_cycle(0, 1, 0, 0, "masked ignored R7");
        ie_set_i = 1'b0;
        run_cycle(1, 0, 0, 0, "reenabled exec R7");
        run_cycle(3, 0, 0, 0, "int again R7");
        int_req_i = 1'b0;
        run_cycle(0, 1, 0, 0, "post int2");
        run_cycle(1, 0, 0, 0, "post int2 exec");
    endtask

    task automatic t_priority_R6();
        ie_set_i = 1'b1; dma_req_i = 1'b1; int_req_i = 1'b1; dma_dir_i = 1'b0;
        run_cycle(0, 1, 0, 0, "prio fetch");
        ie_set_i = 1'b0;
        run_cycle(1, 0, 0, 0, "prio exec");
        dma_req_i = 1'b0;
        run_cycle(2, 1, 0, 0, "dma beats int R6");
        run_cycle(3, 0, 0, 0, "int after dma R7");
        int_req_i = 1'b0;
        run_cycle(0, 1, 0, 0, "prio done");
        run_cycle(1, 0, 0, 0, "prio done exec");
    endtask

    task automatic t_pause_R11();
        for (int ph = 0; ph < 3; ph++) tick();
        #0.2;
        chk("R11 pre-pause phase", phase_o, 3);
        pause_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick();
            #0.2;
            chk("R11 frozen phase", phase_o, 3);
            chk("R11 frozen state", state_code_o, 0);
            chk("R11 frozen read", mrd_n_o, 0);
        end
        pause_i = 1'b0;
        tick();
        #0.2;
        chk("R11 resumed phase", phase_o, 4);
        for (int ph = 4; ph < 8; ph++) tick();
        run_cycle(1, 0, 0, 0, "after pause R11");
        run_cycle(0, 1, 0, 0, "after pause fetch R11");
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        t_reset_R1();
        t_plain_R4();
        t_io_write_R10();
        t_long_R5();
        t_dma_R6();
        t_intr_R7();
        t_priority_R6();
        t_pause_R11();
        finish_up();
    end
endmodule